// File: doc/BRIEF.md
# Camera Control Bus Master

This block drives the two-wire control bus that sets up an image sensor's registers. A requester hands over one command: a device identifier, a register number inside that device, a data byte and a direction flag. The block then runs the whole bus transaction on its own. It drives the clock line and a data line that can be released, with a separate output-enable. It samples the returned line while the data line is released. When the transaction ends, it returns a one-cycle completion pulse and, for reads, the byte it received.

Two requesters share the block through a round-robin arbiter. A granted requester keeps exclusive use of the bus until its stop condition has settled and its completion pulse has been issued, so two transactions can never interleave on the wires.

Bus timing comes from two system-clock tick counts. `SETTLE_TICKS` is the settle interval, nominally 10 us. `CYCLE_TICKS` is the full bit period, nominally 90 us.

Top module: `cambus_master`

## Requirements
- R1: While reset is asserted, and for exactly SETTLE_TICKS clock edges after its release, the block drives `scl`=1, `sda_out`=1 and `sda_oe`=1, and accepts no command: `req_ready` stays 0 for the first SETTLE_TICKS-1 falling-edge samples after release.
- R2: Every transaction opens with a start condition, in which the data line falls while `scl` is high. The clock stays high for a further SETTLE_TICKS cycles before the first bit.
- R3: A write (`req_read`=0) sends exactly three bytes and then a stop condition (data rising while `scl` is high). The bytes are the device identifier with bit 0 forced to 0, then the register number, then the data byte, each MSB first.
- R4: A read (`req_read`=1) sends the identifier with bit 0 forced to 0 and then the register number, followed by a stop and a new start. It then sends the identifier with bit 0 forced to 1, receives one byte MSB first, and ends with a stop. `rd_data` holds the received byte from the cycle in which the completion pulse is high.
- R5: Each bit lasts CYCLE_TICKS clocks, measured between consecutive rising edges of `scl`. `scl` is high for the last CYCLE_TICKS - CYCLE_TICKS/2 clocks of each bit.
- R6: Within a transaction, the data line changes only while `scl` is low, except at start and stop conditions.
- R7: `sda_oe` is 1 during the eight bits of every transmitted byte and 0 during the ninth bit that follows it. `sda_oe` is 0 during the eight bits of a received byte, and during the ninth bit after it the block drives `sda_out`=1 with `sda_oe`=1.
- R8: Each accepted command produces exactly one one-cycle pulse on `req_done`, at the bit of the requester that issued it (bit 0 is port 0).
- R9: `req_ready` has at most one bit set and is 0 from acceptance until completion. When both ports request, the port not granted most recently wins; after reset port 0 wins first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 2 | Command valid, one bit per requester |
| req_ready | output | 2 | Command accepted this cycle when valid is also high |
| req_dev | input | 2x8 | Device identifier per requester (bit 0 ignored) |
| req_reg | input | 2x8 | Register number per requester |
| req_wdata | input | 2x8 | Write byte per requester |
| req_read | input | 2 | 1 selects a read, 0 a write |
| req_done | output | 2 | One-cycle completion pulse per requester |
| rd_data | output | 8 | Byte received by the latest read |
| scl | output | 1 | Bus clock line |
| sda_out | output | 1 | Data line value when driven |
| sda_oe | output | 1 | Data line drive enable |
| sda_in | input | 1 | Sampled data line |

## Verification
The assertions assume that a requester holds `req_valid` and its command fields steady until it sees `req_ready`. They also assume `sda_in` reflects an external device that changes the line only while `scl` is low, and that CYCLE_TICKS is at least 8 with SETTLE_TICKS below it. The bench's device model updates its bit only at falling-edge samples where `scl` is low, and feeds `sda_in` from the driven value whenever `sda_oe` is set. Its requester tasks never drop or change a command before it is accepted.

// File: rtl/cbm_pkg.sv
// Shared types for the camera control bus master.
// Assumes exactly two requesters and byte-wide fields.
package cbm_pkg;
    localparam int NREQ = 2;
    localparam int BW   = 8;

    typedef struct packed {
        logic          rd;
        logic [BW-1:0] dev;
        logic [BW-1:0] reg_no;
        logic [BW-1:0] wdata;
    } cbm_cmd_t;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_STOP,
        ST_STOP_SETTLE
    } cbm_state_t;
endpackage

// File: rtl/cbm_arbiter.sv
// Two-port round-robin arbiter with a bus lock.
// Grants only while the engine is idle and no lock is held. Holds the lock from
// acceptance until the engine's completion pulse, and routes that pulse to the owner.
module cbm_arbiter
    import cbm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_valid,
    input  logic            eng_idle,
    input  logic            eng_done,
    output logic [NREQ-1:0] req_ready,
    output logic            take,
    output logic            pick,
    output logic [NREQ-1:0] done_o
);
    logic last_q;
    logic owner_q;
    logic locked_q;
    logic free;

    // choose a port: alternate on contention, else the only requester
    always_comb begin
        if (req_valid == 2'b11) pick = ~last_q;
        else                    pick = req_valid[1];
        free      = eng_idle && !locked_q;
        req_ready = (free && (|req_valid)) ? (pick ? 2'b10 : 2'b01) : 2'b00;
        take      = |(req_ready & req_valid);
        done_o    = eng_done ? (owner_q ? 2'b10 : 2'b01) : 2'b00;
    end

    // lock and owner bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q   <= 1'b1;
            owner_q  <= 1'b0;
            locked_q <= 1'b0;
        end else if (take) begin
            locked_q <= 1'b1;
            owner_q  <= pick;
            last_q   <= pick;
        end else if (eng_done) begin
            locked_q <= 1'b0;
        end
    end

    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_ready)) else $error("ready not onehot"); // R9
    AST_LOCK_NO_READY: assert property (@(posedge clk) disable iff (!rst_n) locked_q |-> (req_ready == 2'b00)) else $error("ready while locked"); // R9
    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(done_o)) else $error("done not onehot"); // R8
endmodule

// File: rtl/cbm_engine.sv
// Bit-level sequencer for the camera control bus.
// Runs start, byte, stop and restart phases from tick counts of the system clock.
// Assumes CYCLE_TICKS >= 8, SETTLE_TICKS >= 1 and SETTLE_TICKS < CYCLE_TICKS.
// Samples sda_i in the middle of the clock-high phase.
module cbm_engine
    import cbm_pkg::*;
#(
    parameter int SETTLE_TICKS = 240,
    parameter int CYCLE_TICKS  = 2160
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  cbm_cmd_t      cmd_i,
    output logic          idle_o,
    output logic          done_o,
    output logic [BW-1:0] rdata_o,
    output logic          scl_o,
    output logic          sda_o,
    output logic          sda_oe_o,
    input  logic          sda_i
);
    localparam int MAXT = (SETTLE_TICKS > CYCLE_TICKS) ? SETTLE_TICKS : CYCLE_TICKS;
    localparam int TW   = $clog2(MAXT + 1);
    localparam int HALF = CYCLE_TICKS / 2;
    localparam int QTR  = HALF / 2;
    localparam logic [TW-1:0] SET_END = TW'(SETTLE_TICKS - 1);
    localparam logic [TW-1:0] CYC_END = TW'(CYCLE_TICKS - 1);
    localparam logic [TW-1:0] T_QTR   = TW'(QTR);
    localparam logic [TW-1:0] T_RISE  = TW'(HALF - 1);
    localparam logic [TW-1:0] T_SMP   = TW'(HALF + QTR);
    localparam logic [TW-1:0] T_MAX   = TW'(MAXT - 1);

    cbm_state_t    state_q;
    logic [TW-1:0] tick_q;
    logic [3:0]    bitn_q;
    logic [1:0]    byte_idx_q;
    logic          seg_q;
    cbm_cmd_t      cmd_q;
    logic [BW-1:0] rx_q;
    logic [BW-1:0] rdata_q;
    logic          scl_q, sda_q, oe_q, done_q;

    logic [BW-1:0] cur_byte;
    logic [2:0]    bit_sel;
    logic          rx_byte;
    logic [1:0]    last_idx;
    logic          tx_bit;
    logic          drive;

    // byte selection and per-bit line value for the current phase
    always_comb begin
        if (!seg_q) begin
            case (byte_idx_q)
                2'd0:    cur_byte = cmd_q.dev & 8'hFE;
                2'd1:    cur_byte = cmd_q.reg_no;
                default: cur_byte = cmd_q.wdata;
            endcase
        end else begin
            cur_byte = (byte_idx_q == 2'd0) ? (cmd_q.dev | 8'h01) : 8'hFF;
        end
        rx_byte  = cmd_q.rd && seg_q && (byte_idx_q == 2'd1);
        last_idx = cmd_q.rd ? 2'd1 : 2'd2;
        bit_sel  = 3'd7 - bitn_q[2:0];
        tx_bit   = bitn_q[3] ? 1'b1 : cur_byte[bit_sel];
        drive    = bitn_q[3] ? rx_byte : !rx_byte;
    end

    // phase sequencer with tick timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_INIT;
            tick_q     <= '0;
            bitn_q     <= '0;
            byte_idx_q <= '0;
            seg_q      <= 1'b0;
            cmd_q      <= '0;
            rx_q       <= '0;
            rdata_q    <= '0;
            scl_q      <= 1'b1;
            sda_q      <= 1'b1;
            oe_q       <= 1'b1;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            tick_q <= tick_q + 1'b1;
            case (state_q)
                ST_INIT: begin
                    if (tick_q == SET_END) begin
                        state_q <= ST_IDLE;
                        tick_q  <= '0;
                    end
                end
                ST_IDLE: begin
                    tick_q <= '0;
                    if (start_i) begin
                        cmd_q      <= cmd_i;
                        seg_q      <= 1'b0;
                        byte_idx_q <= '0;
                        sda_q      <= 1'b0;
                        state_q    <= ST_START;
                    end
                end
                ST_START: begin
                    if (tick_q == SET_END) begin
                        tick_q  <= '0;
                        bitn_q  <= '0;
                        scl_q   <= 1'b0;
                        state_q <= ST_BIT;
                    end
                end
                ST_BIT: begin
                    if (tick_q == T_QTR) begin
                        sda_q <= tx_bit;
                        oe_q  <= drive;
                    end
                    if (tick_q == T_RISE) scl_q <= 1'b1;
                    if (tick_q == T_SMP && rx_byte && !bitn_q[3])
                        rx_q <= {rx_q[BW-2:0], sda_i};
                    if (tick_q == CYC_END) begin
                        tick_q <= '0;
                        scl_q  <= 1'b0;
                        if (bitn_q[3]) begin
                            bitn_q <= '0;
                            if (byte_idx_q == last_idx) state_q <= ST_STOP;
                            else                        byte_idx_q <= byte_idx_q + 1'b1;
                        end else begin
                            bitn_q <= bitn_q + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick_q == T_QTR) begin
                        sda_q <= 1'b0;
                        oe_q  <= 1'b1;
                    end
                    if (tick_q == T_RISE) scl_q <= 1'b1;
                    if (tick_q == CYC_END) begin
                        sda_q   <= 1'b1;
                        tick_q  <= '0;
                        state_q <= ST_STOP_SETTLE;
                    end
                end
                ST_STOP_SETTLE: begin
                    if (tick_q == SET_END) begin
                        tick_q <= '0;
                        if (cmd_q.rd && !seg_q) begin
                            seg_q      <= 1'b1;
                            byte_idx_q <= '0;
                            sda_q      <= 1'b0;
                            state_q    <= ST_START;
                        end else begin
                            done_q  <= 1'b1;
                            if (cmd_q.rd) rdata_q <= rx_q;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_INIT;
            endcase
        end
    end

    assign idle_o   = (state_q == ST_IDLE);
    assign done_o   = done_q;
    assign rdata_o  = rdata_q;
    assign scl_o    = scl_q;
    assign sda_o    = sda_q;
    assign sda_oe_o = oe_q;

    AST_INIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_INIT) |-> (scl_q && sda_q && oe_q)) else $error("init lines not high"); // R1
    AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_START && $past(state_q) != ST_START) |-> (scl_q && !sda_q)) else $error("bad start"); // R2
    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n) tick_q <= T_MAX) else $error("tick overrun"); // R5
    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_BIT && $past(state_q) == ST_BIT && scl_q && $past(scl_q)) |-> ($stable(sda_q) && $stable(oe_q))) else $error("data moved under high clock"); // R6
    AST_RX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_BIT && rx_byte && !bitn_q[3] && tick_q > T_QTR) |-> !oe_q) else $error("driving during receive"); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q) else $error("done longer than one cycle"); // R8
endmodule

// File: rtl/cambus_master.sv
// Top of the camera control bus master: arbiter plus bit engine.
// Assumes each requester holds valid and its command stable until ready.
module cambus_master
    import cbm_pkg::*;
#(
    parameter int SETTLE_TICKS = 240,
    parameter int CYCLE_TICKS  = 2160
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREQ-1:0]         req_valid,
    output logic [NREQ-1:0]         req_ready,
    input  logic [NREQ-1:0][BW-1:0] req_dev,
    input  logic [NREQ-1:0][BW-1:0] req_reg,
    input  logic [NREQ-1:0][BW-1:0] req_wdata,
    input  logic [NREQ-1:0]         req_read,
    output logic [NREQ-1:0]         req_done,
    output logic [BW-1:0]           rd_data,
    output logic                    scl,
    output logic                    sda_out,
    output logic                    sda_oe,
    input  logic                    sda_in
);
    logic     take, pick, eng_idle, eng_done;
    cbm_cmd_t cmd_sel;

    // forward the granted requester's command to the engine
    always_comb begin
        cmd_sel.rd     = req_read[pick];
        cmd_sel.dev    = req_dev[pick];
        cmd_sel.reg_no = req_reg[pick];
        cmd_sel.wdata  = req_wdata[pick];
    end

    cbm_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .eng_idle  (eng_idle),
        .eng_done  (eng_done),
        .req_ready (req_ready),
        .take      (take),
        .pick      (pick),
        .done_o    (req_done)
    );

    cbm_engine #(
        .SETTLE_TICKS (SETTLE_TICKS),
        .CYCLE_TICKS  (CYCLE_TICKS)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (take),
        .cmd_i    (cmd_sel),
        .idle_o   (eng_idle),
        .done_o   (eng_done),
        .rdata_o  (rd_data),
        .scl_o    (scl),
        .sda_o    (sda_out),
        .sda_oe_o (sda_oe),
        .sda_i    (sda_in)
    );
endmodule

// File: tb/sim_cambus_master.sv
module sim_cambus_master;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE = 4;
    localparam int CYCLE  = 16;
    localparam int HALF_T = CYCLE - CYCLE / 2;
    localparam int NV = 6;
    // fields: port, rd, dev, reg, wdata, slave byte
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h60, 8'h12, 8'h80, 8'h00},
        {1'b1, 1'b1, 8'h60, 8'h1C, 8'h00, 8'h7F},
        {1'b0, 1'b1, 8'h61, 8'h1D, 8'h00, 8'hA2},
        {1'b1, 1'b0, 8'h43, 8'h00, 8'hFF, 8'h00},
        {1'b0, 1'b0, 8'h60, 8'hFF, 8'h00, 8'h00},
        {1'b1, 1'b1, 8'h30, 8'h0A, 8'h00, 8'h96}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] req_valid = '0;
    logic [1:0] req_ready;
    logic [1:0][7:0] req_dev = '0, req_reg = '0, req_wdata = '0;
    logic [1:0] req_read = '0;
    logic [1:0] req_done;
    logic [7:0] rd_data;
    logic scl, sda_out, sda_oe, sda_in;
    logic slv_bit = 1'b1;

    int total = 0, bad = 0;
    int evlog [64]; int evoe [64]; int ev9oe [64]; int ev9v [64]; int evn = 0;
    int expv [16]; int expn = 0;
    int bad_period = 0, bad_high = 0;
    logic [7:0] rx_val = 8'h00;
    int last_port = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_in = sda_oe ? sda_out : slv_bit;

    cambus_master #(.SETTLE_TICKS(SETTLE), .CYCLE_TICKS(CYCLE)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata), .req_read(req_read),
        .req_done(req_done), .rd_data(rd_data), .scl(scl), .sda_out(sda_out),
        .sda_oe(sda_oe), .sda_in(sda_in)
    );

    // bus monitor and device model, sampled at falling clock edges
    logic prev_scl = 1'b1, prev_line = 1'b1, rd_phase = 1'b0, first_rise = 1'b1, hi_valid = 1'b0;
    int bcnt = 0, cyc = 0, last_rise = 0, hi_cnt = 0, oen = 0, nbytes = 0;
    logic [7:0] sh = '0;
    logic n9oe = 1'b0, n9v = 1'b0;
    always @(negedge clk) begin
        logic ln;
        cyc = cyc + 1;
        ln = sda_oe ? sda_out : slv_bit;
        if (!rst_n) begin
            prev_scl = 1'b1; prev_line = 1'b1; bcnt = 0; rd_phase = 1'b0;
            first_rise = 1'b1; hi_valid = 1'b0; slv_bit = 1'b1;
        end else begin
            if (scl && prev_scl && prev_line && !ln) begin
                if (evn < 64) begin evlog[evn] = 256; evn = evn + 1; end
                bcnt = 0; oen = 0; nbytes = 0; first_rise = 1'b1; hi_valid = 1'b0;
            end else if (scl && prev_scl && !prev_line && ln) begin
                if (evn < 64) begin evlog[evn] = 257; evn = evn + 1; end
            end
            if (scl && !prev_scl) begin
                if (!first_rise && (cyc - last_rise) != CYCLE) bad_period = bad_period + 1;
                first_rise = 1'b0; last_rise = cyc; hi_cnt = 1; hi_valid = 1'b1;
                if (bcnt < 8) begin
                    sh = {sh[6:0], ln};
                    if (sda_oe) oen = oen + 1;
                end else begin
                    n9oe = sda_oe; n9v = sda_out;
                end
                bcnt = bcnt + 1;
                if (bcnt == 9) begin
                    if (evn < 64) begin
                        evlog[evn] = int'(sh); evoe[evn] = oen;
                        ev9oe[evn] = int'(n9oe); ev9v[evn] = int'(n9v); evn = evn + 1;
                    end
                    if (rd_phase) rd_phase = 1'b0;
                    else if (nbytes == 0 && sh[0]) rd_phase = 1'b1;
                    nbytes = nbytes + 1; bcnt = 0; oen = 0;
                end
            end else if (scl) begin
                hi_cnt = hi_cnt + 1;
            end else if (prev_scl && hi_valid) begin
                if (hi_cnt != HALF_T) bad_high = bad_high + 1;
                hi_valid = 1'b0;
            end
            if (!scl) slv_bit = (rd_phase && bcnt < 8) ? rx_val[7 - bcnt] : 1'b1;
            prev_scl = scl;
            prev_line = sda_oe ? sda_out : slv_bit;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expd);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expd);
        end
    endtask

    task automatic build_exp(input bit rd, input logic [7:0] dev, input logic [7:0] rg,
                             input logic [7:0] wd, input logic [7:0] rx);
        if (!rd) begin
            expv[0] = 256; expv[1] = int'(dev & 8'hFE); expv[2] = int'(rg);
            expv[3] = int'(wd); expv[4] = 257; expn = 5;
        end else begin
            expv[0] = 256; expv[1] = int'(dev & 8'hFE); expv[2] = int'(rg); expv[3] = 257;
            expv[4] = 256; expv[5] = int'(dev | 8'h01); expv[6] = int'(rx); expv[7] = 257; expn = 8;
        end
    endtask

    // compare the bus log with the expected event list and the drive pattern
    task automatic check_bus(input bit rd);
        int mism = 0, oebad = 0;
        check(evn >= 1 && evlog[0] == 256, "R2 start first", evlog[0], 256);
        for (int k = 0; k < expn; k++)
            if (k >= evn || evlog[k] != expv[k]) mism = mism + 1;
        if (evn != expn) mism = mism + 1;
        check(mism == 0, rd ? "R4 R6 read sequence" : "R3 R6 write sequence", evn, expn);
        for (int k = 0; k < evn; k++) begin
            if (evlog[k] < 256) begin
                if (rd && k == 6) begin
                    if (evoe[k] != 0 || ev9oe[k] != 1 || ev9v[k] != 1) oebad = oebad + 1;
                end else begin
                    if (evoe[k] != 8 || ev9oe[k] != 0) oebad = oebad + 1;
                end
            end
        end
        check(oebad == 0, "R7 drive pattern", oebad, 0);
    endtask

    task automatic load(input int p, input bit rd, input logic [7:0] dev,
                        input logic [7:0] rg, input logic [7:0] wd);
        req_read[p] = rd; req_dev[p] = dev; req_reg[p] = rg; req_wdata[p] = wd;
        req_valid[p] = 1'b1;
    endtask

    task automatic wait_accept(input int p);
        while (1) begin
            #1;
            if (req_ready[p]) begin
                @(negedge clk);
                req_valid[p] = 1'b0;
                last_port = p;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic wait_done(input int p, input bit rd, input logic [7:0] rx);
        while (req_done == 2'b00) @(negedge clk);
        check(req_done == (2'b01 << p), "R8 done port", int'(req_done), int'(2'b01 << p));
        if (rd) check(rd_data == rx, "R4 read data", int'(rd_data), int'(rx));
        @(negedge clk);
        check(req_done == 2'b00, "R8 single pulse", int'(req_done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1; bad = bad + 1;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int p;
        logic rd;
        repeat (3) @(negedge clk);
        // R1: reset levels and no acceptance during reset
        check(scl && sda_out && sda_oe, "R1 reset lines", {scl, sda_out, sda_oe}, 7);
        load(0, 1'b0, 8'h60, 8'h55, 8'hC3);
        #1;
        check(req_ready == 2'b00, "R1 no ready in reset", int'(req_ready), 0);
        evn = 0;
        rst_n = 1'b1;
        n = 0;
        while (1) begin
            @(negedge clk);
            #1;
            if (req_ready[0]) break;
            if (!(scl && sda_out && sda_oe)) n = n + 100;
            n = n + 1;
        end
        check(n == SETTLE - 1, "R1 settle after reset", n, SETTLE - 1);
        @(negedge clk);
        req_valid[0] = 1'b0; last_port = 0;
        rx_val = 8'h00;
        build_exp(1'b0, 8'h60, 8'h55, 8'hC3, 8'h00);
        wait_done(0, 1'b0, 8'h00);
        check_bus(1'b0);

        // table of commands
        for (int v = 0; v < NV; v++) begin
            p  = int'(VEC[v][33]);
            rd = VEC[v][32];
            rx_val = VEC[v][7:0];
            build_exp(rd, VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
            evn = 0;
            @(negedge clk);
            load(p, rd, VEC[v][31:24], VEC[v][23:16], VEC[v][15:8]);
            wait_accept(p);
            wait_done(p, rd, VEC[v][7:0]);
            check_bus(rd);
        end

        // R9: contention, round-robin choice and lock
        begin
            int win, lose, leak;
            win = (last_port == 0) ? 1 : 0;
            lose = 1 - win;
            rx_val = 8'h00;
            evn = 0;
            @(negedge clk);
            load(0, 1'b0, 8'h60, 8'h01, 8'hA0);
            load(1, 1'b0, 8'h62, 8'h02, 8'hB0);
            #1;
            check(req_ready == (2'b01 << win), "R9 round robin pick", int'(req_ready), int'(2'b01 << win));
            @(negedge clk);
            req_valid[win] = 1'b0;
            leak = 0;
            while (req_done == 2'b00) begin
                #1;
                if (req_ready != 2'b00) leak = leak + 1;
                @(negedge clk);
            end
            check(leak == 0, "R9 lock holds", leak, 0);
            check(req_done == (2'b01 << win), "R8 done to winner", int'(req_done), int'(2'b01 << win));
            if (win == 0) build_exp(1'b0, 8'h60, 8'h01, 8'hA0, 8'h00);
            else          build_exp(1'b0, 8'h62, 8'h02, 8'hB0, 8'h00);
            check_bus(1'b0);
            evn = 0;
            @(negedge clk);
            wait_accept(lose);
            wait_done(lose, 1'b0, 8'h00);
            if (lose == 0) build_exp(1'b0, 8'h60, 8'h01, 8'hA0, 8'h00);
            else           build_exp(1'b0, 8'h62, 8'h02, 8'hB0, 8'h00);
            check_bus(1'b0);
        end

        // R5: bit period and clock-high width over every transaction above
        check(bad_period == 0, "R5 bit period", bad_period, 0);
        check(bad_high == 0, "R5 clock high width", bad_high, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule